// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Converter Front End

This block is the digital side of a 16-bit digital-to-analog converter that sits on an 8-bit processor bus. A processor builds the 16-bit converter code in two holding registers, one for the lower byte and one for the upper byte. It then moves the assembled word into a second output register, which drives the converter. Because of this double buffering, a new code is prepared without disturbing the analog output, and the output changes in a single step.

The two byte enables work like address lines. Asserting one of them selects the low or the high holding register. Asserting both of them turns bus bit 0 into a serial input, and the word shifts in with the most significant bit first. A third enable triggers the transfer into the output register.

Every register acts only on the falling edge of the write strobe, sampled on the system clock, while chip select is low. The clear input empties both holding registers and loads the output register with the bipolar-zero code. The coding is two's complement. A build parameter inverts the top output bit so that straight-binary (unipolar) codes can be used.

Top module: `dac_byte_front`

## Requirements
- R1: After a synchronous reset, both holding registers are zero and `code` equals the clear code: 0000h when UNIPOLAR=0, 8000h when UNIPOLAR=1.
- R2: A write with `sel_lo_n` low and `sel_hi_n` high stores `bus[7:0]` as bits 7:0 of the input word and leaves bits 15:8 unchanged.
- R3: A write with `sel_hi_n` low and `sel_lo_n` high stores `bus[7:0]` as bits 15:8 of the input word and leaves bits 7:0 unchanged.
- R4: A register changes on a write only when `cs_n` is low at the same clock edge. A write with `cs_n` high changes neither the holding registers nor `code`.
- R5: A write acts once, on the clock edge where `wr_n` is first sampled low after being high. Holding `wr_n` low over later cycles has no further effect, even if the bus changes.
- R6: A write with both `sel_lo_n` and `sel_hi_n` low shifts `bus[0]` into bit 0 of the 16-bit input word, moving the other bits up by one. After 16 such writes, the first bit sent sits in bit 15.
- R7: `code` changes only on a write with `xfer_n` low. Byte and serial writes without it leave `code` unchanged.
- R8: When `xfer_n` is low in the same write as a byte or serial load, `code` takes the input word as updated by that write.
- R9: When `clr_n` is sampled low, both holding registers become zero and `code` becomes the clear code at that clock edge. Clear overrides any write, load or transfer in the same cycle.
- R10: With UNIPOLAR=1, `code` equals the transferred input word with bit 15 inverted. With UNIPOLAR=0, `code` equals the transferred input word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; acts on its falling edge |
| clr_n | input | 1 | Clear, active low |
| sel_lo_n | input | 1 | Low-byte register enable, active low |
| sel_hi_n | input | 1 | High-byte register enable, active low |
| xfer_n | input | 1 | Output register transfer enable, active low |
| bus | input | 8 | Data bus; bit 0 is the serial input in serial mode |
| code | output | 16 | Registered converter code |

## Verification
Each write, clear and reset shows up on `code` at the first rising clock edge where it is sampled. The bench therefore drives inputs on falling edges, lets exactly one rising edge pass, and reads `code` on the next falling edge. The contents of the holding registers cannot be seen directly, so the bench follows each load with a transfer-only write and reads the result on `code` one edge later. Two instances, one built bipolar and one unipolar, receive the same stimulus and are compared against the same expected word, with bit 15 inverted for the unipolar instance.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

  typedef enum logic [1:0] {
    LD_NONE   = 2'd0,
    LD_LOW    = 2'd1,
    LD_HIGH   = 2'd2,
    LD_SERIAL = 2'd3
  } load_e;

  // Active-low byte enables to load kind; both low selects serial shifting.
  function automatic load_e decode_load(input logic lo_n, input logic hi_n);
    case ({hi_n, lo_n})
      2'b00:   return LD_SERIAL;
      2'b10:   return LD_LOW;
      2'b01:   return LD_HIGH;
      default: return LD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dac_wr_strobe.sv
module dac_wr_strobe (
  input  logic clk,
  input  logic rst,
  input  logic wr_n,
  input  logic cs_n,
  output logic strobe
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  // Fires on the first sampled low of the strobe, gated by chip select.
  assign strobe = wr_q & ~wr_n & ~cs_n;
endmodule

// File: rtl/dac_input_regs.sv
module dac_input_regs
  import dac_front_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              strobe,
  input  load_e             load,
  input  logic [BYTE_W-1:0] bus,
  output logic [WORD_W-1:0] word_next
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [BYTE_W-1:0] lo_d, hi_d;
  logic [WORD_W-1:0] shifted;

  assign shifted = {hi_q[BYTE_W-2:0], lo_q, bus[0]};

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (clr) begin
      lo_d = '0;
      hi_d = '0;
    end else if (strobe) begin
      case (load)
        LD_LOW:    lo_d = bus;
        LD_HIGH:   hi_d = bus;
        LD_SERIAL: {hi_d, lo_d} = shifted;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // Post-update word so a same-write transfer passes new data through.
  assign word_next = {hi_d, lo_d};
endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg #(
  parameter int WORD_W   = 16,
  parameter bit UNIPOLAR = 1'b0,
  localparam logic [WORD_W-1:0] FLIP = UNIPOLAR ? {1'b1, {(WORD_W-1){1'b0}}} : '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fire,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst || clr)  code <= FLIP;
    else if (fire)   code <= word_in ^ FLIP;
  end
endmodule

// File: rtl/dac_byte_front.sv
module dac_byte_front
  import dac_front_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter bit UNIPOLAR = 1'b0,
  localparam int WORD_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              clr_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi_n,
  input  logic              xfer_n,
  input  logic [BYTE_W-1:0] bus,
  output logic [WORD_W-1:0] code
);
  logic              strobe;
  logic              clr;
  load_e             load;
  logic [WORD_W-1:0] word_next;

  assign clr  = ~clr_n;
  assign load = decode_load(sel_lo_n, sel_hi_n);

  dac_wr_strobe u_strobe (
    .clk    (clk),
    .rst    (rst),
    .wr_n   (wr_n),
    .cs_n   (cs_n),
    .strobe (strobe)
  );

  dac_input_regs #(.BYTE_W(BYTE_W)) u_inregs (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .strobe    (strobe),
    .load      (load),
    .bus       (bus),
    .word_next (word_next)
  );

  dac_out_reg #(.WORD_W(WORD_W), .UNIPOLAR(UNIPOLAR)) u_outreg (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .fire    (strobe & ~xfer_n),
    .word_in (word_next),
    .code    (code)
  );
endmodule

// File: rtl/dac_byte_front_chk.sv
module dac_byte_front_chk #(
  parameter int BYTE_W   = 8,
  parameter bit UNIPOLAR = 1'b0,
  localparam int WORD_W  = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_n,
  input logic              clr_n,
  input logic              xfer_n,
  input logic [WORD_W-1:0] code
);
  localparam logic [WORD_W-1:0] ZERO_CODE =
    UNIPOLAR ? (WORD_W'(1) << (WORD_W - 1)) : '0;

  logic wr_seen = 1'b1;
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    wr_seen  <= rst ? 1'b1 : wr_n;
    rst_seen <= rst;
  end

  // R1: the cycle after reset shows the clear code
  always_ff @(posedge clk) begin
    if (rst_seen) assert_reset_code_R1: assert (code == ZERO_CODE);
  end

  // R9: clear lands within one edge
  assert_clear_code_R9: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> code == ZERO_CODE);

  // R4: no chip select, no change
  assert_no_cs_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_n && clr_n) |=> $stable(code));

  // R5: a held-low strobe does not act again
  assert_held_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !wr_seen && clr_n) |=> $stable(code));

  // R7: without transfer enable the output holds
  assert_no_xfer_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_n && clr_n) |=> $stable(code));
endmodule

bind dac_byte_front dac_byte_front_chk #(.BYTE_W(BYTE_W), .UNIPOLAR(UNIPOLAR)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (cs_n),
  .wr_n   (wr_n),
  .clr_n  (clr_n),
  .xfer_n (xfer_n),
  .code   (code)
);

// File: tb/dac_byte_front_tb.sv
module dac_byte_front_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, clr_n = 1'b1;
  logic sel_lo_n = 1'b1, sel_hi_n = 1'b1, xfer_n = 1'b1;
  logic [7:0] bus = 8'h00;
  logic [15:0] code_b, code_u;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_byte_front #(.UNIPOLAR(1'b0)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .clr_n(clr_n),
    .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .xfer_n(xfer_n),
    .bus(bus), .code(code_b));

  dac_byte_front #(.UNIPOLAR(1'b1)) u_dut_uni (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .clr_n(clr_n),
    .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .xfer_n(xfer_n),
    .bus(bus), .code(code_u));

  // fields: cs_n, clr_n, sel_lo_n, sel_hi_n, xfer_n, bus, expected bipolar code
  typedef struct packed {
    logic       cs; logic clr; logic lo; logic hi; logic xf;
    logic [7:0] d; logic [15:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b1,8'hA5,16'h0000}, // R2/R7 low byte, no transfer
    '{1'b0,1'b1,1'b1,1'b0,1'b1,8'h3C,16'h0000}, // R3/R7 high byte, no transfer
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,16'h3CA5}, // R7 transfer only
    '{1'b1,1'b1,1'b0,1'b1,1'b0,8'hFF,16'h3CA5}, // R4 chip select high
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,16'h3CA5}, // R4 low byte untouched
    '{1'b0,1'b1,1'b0,1'b1,1'b0,8'h11,16'h3C11}, // R8 low byte pass-through
    '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h80,16'h8011}, // R8 high byte pass-through
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h77,16'h0000}, // R9 clear beats write
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,16'h0000}, // R9 holding registers zeroed
    '{1'b0,1'b1,1'b1,1'b0,1'b1,8'hFF,16'h0000}, // R3 high byte alone
    '{1'b0,1'b1,1'b0,1'b1,1'b0,8'h01,16'hFF01}  // R2 low byte keeps high
  };

  task automatic check(input string req, input logic [15:0] exp);
    n_run++;
    if (code_b !== exp) begin
      n_fail++;
      $display("FAIL %s bipolar: code=%h expected=%h", req, code_b, exp);
    end
    n_run++;
    if (code_u !== (exp ^ 16'h8000)) begin
      n_fail++;
      $display("FAIL %s unipolar R10: code=%h expected=%h", req, code_u, exp ^ 16'h8000);
    end
  endtask

  // One write: strobe low for one edge, then released; sample after.
  task automatic do_wr(input logic cs, input logic clr, input logic lo,
                       input logic hi, input logic xf, input logic [7:0] d);
    @(negedge clk);
    cs_n = cs; clr_n = clr; sel_lo_n = lo; sel_hi_n = hi; xfer_n = xf; bus = d;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; clr_n = 1'b1;
    sel_lo_n = 1'b1; sel_hi_n = 1'b1; xfer_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      do_wr(VECS[i].cs, VECS[i].clr, VECS[i].lo, VECS[i].hi, VECS[i].xf, VECS[i].d);
      check($sformatf("vector%0d", i), VECS[i].exp);
    end

    // R5: held strobe captures only its first edge
    @(negedge clk);
    cs_n = 1'b0; sel_lo_n = 1'b0; bus = 8'h42; wr_n = 1'b0;
    @(negedge clk);
    bus = 8'h99;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; sel_lo_n = 1'b1;
    check("R5 held (R7 no transfer)", 16'hFF01);
    do_wr(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R5", 16'hFF42);

    // R6: serial load MSB first, transfer afterwards
    begin
      logic [15:0] pat = 16'hB3E1;
      for (int b = 15; b >= 0; b--) begin
        do_wr(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, {7'h55, pat[b]});
      end
      check("R6 before transfer", 16'hFF42);
      do_wr(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      check("R6", pat);
      // R8: serial shift with transfer in the same write
      do_wr(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R6 R8 serial pass-through", 16'h67C2);
    end

    // R9: clear without any write strobe
    @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    check("R9 standalone", 16'h0000);

    // R1: reset mid-operation
    do_wr(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A);
    check("R3 before reset", 16'h5A00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run", 16'h0000);
    do_wr(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R1 registers zeroed", 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule